// File: doc/BRIEF.md
# Dual-Scheme Serial Clock Tick Generator

This block derives the timing reference for a serial-peripheral shift engine from the module clock. It does not drive the serial clock pin itself. It emits a one-cycle tick at twice the serial clock rate, and the shift engine toggles its clock line once per tick. One serial clock period is therefore two tick intervals. A 13-bit control word selects one of two ways to encode the division ratio:

- a coarse power-of-two scheme, driven by a 4-bit exponent;
- a fine linear scheme that yields even ratios, driven by an 8-bit setting.

The overall ratio is never below 2, so the serial clock never runs faster than half the module clock.

The generator runs only while `run` is high. When `run` drops, the interval counter returns to zero and ticks stop. A control word that changes while the generator runs is held back until the current tick interval ends. This ensures that no shortened half-period ever reaches the serial clock line. While the generator is stopped, each cycle is an idle point, so a new control word is taken up at once.

Top module: `sclk_tick_gen`

## Requirements
- R1: Bit 12 of `div_ctrl` selects the scheme. A value of 0 selects the power-of-two exponent in bits 11:8, and a value of 1 selects the linear setting in bits 7:0. The field of the unselected scheme has no effect.
- R2: In power-of-two mode with exponent n from 1 to 15, the ratio is 2^n, so consecutive ticks are 2^(n-1) module cycles apart.
- R3: In power-of-two mode, an exponent of 0 gives the minimum ratio of 2, with a tick on every module cycle. No setting in either mode gives a ratio below 2.
- R4: In linear mode with setting N from 0 to 255, the ratio is 2*(N+1), so consecutive ticks are N+1 module cycles apart.
- R5: When the tick interval is longer than one cycle, `tick` is high for exactly one module cycle per interval.
- R6: While `run` is low, `tick` stays low and the interval restarts. After `run` rises, the first tick is output on the same clock edge as the interval's P-th edge with `run` high, where P is the tick spacing.
- R7: A control word changed while running does not alter the interval in progress. It takes effect starting with the interval after the next tick.
- R8: A control word changed while `run` is low takes effect for the first interval after `run` rises.
- R9: During reset, `tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Generator enable; low stops ticks and clears the interval |
| div_ctrl | input | 13 | Control word: bit 12 scheme select, 11:8 exponent, 7:0 linear setting |
| tick | output | 1 | One-cycle pulse at twice the serial clock rate |

## Verification
The bound checker covers the properties that hold on every cycle:
- ticks are silent and the counter is cleared while stopped;
- the counter stays below the applied spacing, and that spacing is never zero;
- the applied setting moves only at an interval end or while stopped;
- ticks are single-cycle whenever the spacing exceeds one.

Only the directed scenarios can show that each encoding yields the correct spacing. They measure tick-to-tick gaps and enable-to-first-tick latency across both schemes and both extremes of each field. They also check that a mid-interval control change finishes the old interval before switching, and that the unselected field is ignored.

// File: rtl/sclk_tick_pkg.sv
package sclk_tick_pkg;

  // Scheme select values carried in the control word
  typedef enum logic {
    SCHEME_POW2 = 1'b0,
    SCHEME_LIN  = 1'b1
  } scheme_e;

  // Default field widths of the control word
  localparam int DEF_EXP_W = 4;
  localparam int DEF_LIN_W = 8;

endpackage

// File: rtl/sclk_tick_decode.sv
module sclk_tick_decode #(
  parameter int EXP_W = sclk_tick_pkg::DEF_EXP_W,
  parameter int LIN_W = sclk_tick_pkg::DEF_LIN_W,
  parameter int CW    = LIN_W + EXP_W + 1,
  parameter int HP_W  = 15
) (
  input  logic [CW-1:0]   ctrl,
  output logic [HP_W-1:0] half_period
);
  import sclk_tick_pkg::*;

  localparam int EXP_LSB = LIN_W;
  localparam int SEL_POS = LIN_W + EXP_W;

  // Tick spacing for the power-of-two scheme: ratio 2^n, exponent 0 gives ratio 2
  function automatic logic [HP_W-1:0] pow2_spacing(input logic [EXP_W-1:0] e);
    logic [HP_W-1:0] one;
    one = HP_W'(1);
    if (e == '0) return one;
    return one << (e - EXP_W'(1));
  endfunction

  // Tick spacing for the linear scheme: ratio 2*(N+1)
  function automatic logic [HP_W-1:0] lin_spacing(input logic [LIN_W-1:0] n);
    return HP_W'(n) + HP_W'(1);
  endfunction

  scheme_e          scheme;
  logic [EXP_W-1:0] exp_field;
  logic [LIN_W-1:0] lin_field;

  always_comb begin
    scheme    = scheme_e'(ctrl[SEL_POS]);
    exp_field = ctrl[EXP_LSB +: EXP_W];
    lin_field = ctrl[0 +: LIN_W];
    if (scheme == SCHEME_LIN) half_period = lin_spacing(lin_field);
    else                      half_period = pow2_spacing(exp_field);
  end

endmodule

// File: rtl/sclk_tick_counter.sv
module sclk_tick_counter #(
  parameter int HP_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HP_W-1:0] hp_next,
  output logic            tick,
  output logic            wrap,
  output logic [HP_W-1:0] cnt,
  output logic [HP_W-1:0] hp_act
);

  logic [HP_W-1:0] last_idx;

  assign last_idx = hp_act - HP_W'(1);
  assign wrap     = run && (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      hp_act <= HP_W'(1);
      tick   <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      hp_act <= hp_next;
      tick   <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      hp_act <= hp_next;
      tick   <= 1'b1;
    end else begin
      cnt    <= cnt + HP_W'(1);
      tick   <= 1'b0;
    end
  end

endmodule

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
  parameter int EXP_W = sclk_tick_pkg::DEF_EXP_W,
  parameter int LIN_W = sclk_tick_pkg::DEF_LIN_W,
  localparam int CW      = LIN_W + EXP_W + 1,
  localparam int POW_HPW = (1 << EXP_W) - 1,
  localparam int LIN_HPW = LIN_W + 1,
  localparam int HP_W    = (POW_HPW > LIN_HPW) ? POW_HPW : LIN_HPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] div_ctrl,
  output logic          tick
);

  logic [HP_W-1:0] hp_next;
  logic [HP_W-1:0] hp_act;
  logic [HP_W-1:0] cnt;
  logic            wrap;

  sclk_tick_decode #(
    .EXP_W(EXP_W), .LIN_W(LIN_W), .CW(CW), .HP_W(HP_W)
  ) u_decode (
    .ctrl        (div_ctrl),
    .half_period (hp_next)
  );

  sclk_tick_counter #(
    .HP_W(HP_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .hp_next (hp_next),
    .tick    (tick),
    .wrap    (wrap),
    .cnt     (cnt),
    .hp_act  (hp_act)
  );

endmodule

// File: rtl/sclk_tick_gen_chk.sv
module sclk_tick_gen_chk #(
  parameter int HP_W = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            tick,
  input logic            wrap,
  input logic [HP_W-1:0] cnt,
  input logic [HP_W-1:0] hp_act
);

  // R6
  stopped_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);

  // R6
  stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R7
  setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(hp_act));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hp_act != HP_W'(1)) |=> !tick);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < hp_act);

  // R3
  min_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_act != '0);

endmodule

bind sclk_tick_gen sclk_tick_gen_chk #(.HP_W(HP_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (run),
  .tick   (tick),
  .wrap   (wrap),
  .cnt    (cnt),
  .hp_act (hp_act)
);

// File: tb/sclk_tick_gen_bench.sv
module sclk_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [12:0] div_ctrl = '0;
  logic        tick;

  int n_checks = 0;
  int n_fail   = 0;

  localparam int LIMIT = 70000;

  always #5 clk = ~clk;

  sclk_tick_gen u_sclk_tick_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .div_ctrl(div_ctrl), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] pow2_word(input int n);
    return {1'b0, 4'(n), 8'h00};
  endfunction

  function automatic logic [12:0] lin_word(input int n);
    return {1'b1, 4'h0, 8'(n)};
  endfunction

  // cycles from current negedge until tick is seen
  task automatic wait_tick(output int cycles);
    cycles = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      cycles++;
      if (tick) break;
    end
  endtask

  // stop, load a word, enable, check first-tick latency and gap
  task automatic run_word(input logic [12:0] w, input int p, input string req);
    int lat;
    int gap;
    run = 1'b0;
    div_ctrl = w;
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    wait_tick(lat);
    check(lat == p, {req, " first tick latency"}, lat, p);
    wait_tick(gap);
    check(gap == p, {req, " tick spacing"}, gap, p);
  endtask

  task automatic t_reset;
    check(tick == 1'b0, "R9 tick low in reset", int'(tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R6 idle after reset", int'(tick), 0);
  endtask

  task automatic t_pow2;
    run_word(pow2_word(1), 1, "R2 exp1");
    run_word(pow2_word(3), 4, "R2 exp3");
    run_word(pow2_word(5), 16, "R2 exp5");
    run_word(pow2_word(15), 16384, "R2 exp15");
  endtask

  task automatic t_min;
    run_word(pow2_word(0), 1, "R3 exp0");
    run_word(lin_word(0), 1, "R3 lin0");
  endtask

  task automatic t_lin;
    run_word(lin_word(1), 2, "R4 lin1");
    run_word(lin_word(7), 8, "R4 lin7");
    run_word(lin_word(255), 256, "R4 lin255");
  endtask

  task automatic t_select;
    run_word({1'b0, 4'd3, 8'd9}, 4, "R1 sel0 ignores linear field");
    run_word({1'b1, 4'd3, 8'd9}, 10, "R1 sel1 ignores exponent");
  endtask

  task automatic t_pulse;
    int lat;
    run_word(pow2_word(3), 4, "R5 setup");
    wait_tick(lat);
    @(negedge clk);
    check(tick == 1'b0, "R5 tick one cycle wide", int'(tick), 0);
  endtask

  task automatic t_stop;
    int cnt;
    run_word(lin_word(2), 3, "R6 setup");
    run = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check(cnt == 0, "R6 no ticks while stopped", cnt, 0);
  endtask

  task automatic t_change_running;
    int g;
    run_word(lin_word(3), 4, "R7 setup");
    @(negedge clk);
    div_ctrl = lin_word(1);
    wait_tick(g);
    check(g == 3, "R7 interval in progress completes", g, 3);
    wait_tick(g);
    check(g == 2, "R7 new spacing after tick", g, 2);
  endtask

  task automatic t_change_stopped;
    int lat;
    run = 1'b0;
    div_ctrl = lin_word(20);
    @(negedge clk);
    div_ctrl = pow2_word(4);
    @(negedge clk);
    div_ctrl = lin_word(5);
    @(negedge clk);
    run = 1'b1;
    wait_tick(lat);
    check(lat == 6, "R8 last stopped word applies", lat, 6);
  endtask

  initial begin
    t_reset();
    t_pow2();
    t_min();
    t_lin();
    t_select();
    t_pulse();
    t_stop();
    t_change_running();
    t_change_stopped();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule